// File: doc/BRIEF.md
# I2C General-Call Software Reset Detector

This block sits behind a bit-level I2C target front end and watches the byte-level event stream it produces: START (or repeated START) strobes, STOP strobes and completed received bytes. It recognizes the general-call software reset sequence. The sequence is a START, then the all-zero write address, then exactly one command byte of value 06h, then a STOP. For every byte that belongs to this sequence, the block decides whether the front end should drive an acknowledge.

When the whole sequence is complete, the block emits a single-clock reset pulse to the rest of the device. Any deviation cancels the pending reset and leaves the block silent until the next START. Deviations are a wrong command value, a second command byte, a repeated START in place of the STOP, or an address read. The front end's bit timing and the registers that the pulse clears are handled by other logic.

The matched address, the command value and the byte width are parameters. A parameter also selects whether the acknowledge decision is presented combinationally with the byte strobe or one clock later.

Top module: `swrst_gc_detect`

## Requirements
- R1: After `rst_n` is released, `ack_o` and `swrst_o` are 0, and the block waits for a START before it acknowledges any byte.
- R2: In the default combinational mode, the first byte after a START is acknowledged (`ack_o`=1 in the same cycle as `byte_vld_i`) when it equals 00h, which is the all-zero address with R/W bit 0 = write.
- R3: A first byte that is not 00h is not acknowledged. This includes 01h, the all-zero address with R/W=1. Every later byte up to the next START is then not acknowledged.
- R4: The one byte after an acknowledged 00h address is acknowledged if and only if it equals 06h.
- R5: A command byte other than 06h is not acknowledged and cancels the sequence, so a following STOP produces no reset pulse.
- R6: Any further byte after an accepted 06h is not acknowledged and cancels the pending reset.
- R7: A STOP that directly follows the accepted 06h makes `swrst_o` high for exactly one clock, in the cycle after the STOP strobe.
- R8: A repeated START in place of that STOP produces no reset pulse.
- R9: A START at any point returns the block to waiting for the address byte, so a fresh 00h is acknowledged again.
- R10: Bytes received after a STOP and before the next START are never acknowledged.
- R11: When a START strobe arrives in the same cycle as a STOP or a byte, the START wins. That byte is not acknowledged, and that STOP produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe: START or repeated START seen on the bus |
| stop_i | input | 1 | One-cycle strobe: STOP seen on the bus |
| byte_vld_i | input | 1 | One-cycle strobe: a complete byte is in `byte_i` |
| byte_i | input | BYTE_W | Received byte, R/W bit in bit 0 for address bytes |
| ack_o | output | 1 | Acknowledge decision for the current byte |
| swrst_o | output | 1 | One-cycle software reset pulse |

## Verification
The assertions check several properties on every cycle. The reset pulse never lasts more than one clock and is always preceded by a STOP strobe. No byte other than the address or the command value is ever acknowledged. A START strobe suppresses both the acknowledge and the next-cycle pulse. Whether a pulse follows depends on the exact history of bytes since the last START: the wrong command, the extra byte, the repeated START and the read address. Those orderings are only shown by the bench's scenarios, which compare the pulse and acknowledge cycle by cycle against expected values.

// File: rtl/swrst_gc_pkg.sv
package swrst_gc_pkg;
   typedef enum logic [2:0] {
      SG_IDLE  = 3'd0,  // no START seen since STOP or reset
      SG_ADDR  = 3'd1,  // expecting the address byte
      SG_CMD   = 3'd2,  // general call taken, expecting command
      SG_ARMED = 3'd3,  // command accepted, reset pending on STOP
      SG_DROP  = 3'd4   // sequence rejected until next START
   } sg_state_e;
endpackage

// File: rtl/swrst_byte_match.sv
module swrst_byte_match #(
   parameter int unsigned BYTE_W  = 8,
   parameter logic [BYTE_W-1:0] GC_ADDR = '0,
   parameter logic [BYTE_W-1:0] CMD_VAL = BYTE_W'(6)
) (
   input  logic [BYTE_W-1:0] byte_i,
   output logic              is_gc_wr_o,
   output logic              is_cmd_o
);
   // The whole byte is compared, so the R/W bit (bit 0) must be 0 for a match.
   assign is_gc_wr_o = (byte_i == GC_ADDR);
   assign is_cmd_o   = (byte_i == CMD_VAL);
endmodule

// File: rtl/swrst_seq_fsm.sv
module swrst_seq_fsm
   import swrst_gc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   input  logic byte_vld_i,
   input  logic is_gc_wr_i,
   input  logic is_cmd_i,
   output logic ack_c_o,
   output logic fire_c_o
);
   sg_state_e st_q, st_d;

   always_comb begin
      st_d     = st_q;
      ack_c_o  = 1'b0;
      fire_c_o = 1'b0;
      if (start_i) begin
         st_d = SG_ADDR;
      end else if (stop_i) begin
         st_d     = SG_IDLE;
         fire_c_o = (st_q == SG_ARMED);
      end else if (byte_vld_i) begin
         unique case (st_q)
            SG_ADDR: begin
               if (is_gc_wr_i) begin
                  ack_c_o = 1'b1;
                  st_d    = SG_CMD;
               end else begin
                  st_d = SG_DROP;
               end
            end
            SG_CMD: begin
               if (is_cmd_i) begin
                  ack_c_o = 1'b1;
                  st_d    = SG_ARMED;
               end else begin
                  st_d = SG_DROP;
               end
            end
            SG_ARMED: st_d = SG_DROP;
            default:  st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SG_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/swrst_gc_detect.sv
module swrst_gc_detect #(
   parameter int unsigned BYTE_W  = 8,
   parameter logic [BYTE_W-1:0] GC_ADDR = '0,
   parameter logic [BYTE_W-1:0] CMD_VAL = BYTE_W'(6),
   parameter bit ACK_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              ack_o,
   output logic              swrst_o
);
   localparam int unsigned RW_BIT = 0;

   if (BYTE_W < 2) begin : g_chk_w
      $error("BYTE_W must be at least 2");
   end
   if (GC_ADDR[RW_BIT] != 1'b0) begin : g_chk_rw
      $error("GC_ADDR must carry the write direction");
   end
   if (GC_ADDR == CMD_VAL) begin : g_chk_dist
      $error("GC_ADDR and CMD_VAL must differ");
   end

   logic is_gc_wr, is_cmd, ack_c, fire_c;
   logic swrst_q;

   swrst_byte_match #(
      .BYTE_W (BYTE_W),
      .GC_ADDR(GC_ADDR),
      .CMD_VAL(CMD_VAL)
   ) u_match (
      .byte_i    (byte_i),
      .is_gc_wr_o(is_gc_wr),
      .is_cmd_o  (is_cmd)
   );

   swrst_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .stop_i    (stop_i),
      .byte_vld_i(byte_vld_i),
      .is_gc_wr_i(is_gc_wr),
      .is_cmd_i  (is_cmd),
      .ack_c_o   (ack_c),
      .fire_c_o  (fire_c)
   );

   if (ACK_REG) begin : g_ack_reg
      logic ack_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ack_q <= 1'b0;
         else        ack_q <= ack_c;
      end
      assign ack_o = ack_q;
   end else begin : g_ack_comb
      assign ack_o = ack_c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) swrst_q <= 1'b0;
      else        swrst_q <= fire_c;
   end
   assign swrst_o = swrst_q;
endmodule

// File: rtl/swrst_gc_checker.sv
module swrst_gc_checker #(
   parameter int unsigned BYTE_W  = 8,
   parameter logic [BYTE_W-1:0] GC_ADDR = '0,
   parameter logic [BYTE_W-1:0] CMD_VAL = BYTE_W'(6),
   parameter bit ACK_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              stop_i,
   input logic              byte_vld_i,
   input logic [BYTE_W-1:0] byte_i,
   input logic              ack_o,
   input logic              swrst_o
);
   // R7: pulse lasts a single clock
   p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      swrst_o |=> !swrst_o);

   // R7: pulse only in the cycle after a STOP strobe
   p_pulse_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      swrst_o |-> $past(stop_i));

   // R11 / R8: a START strobe blocks the next-cycle pulse
   p_start_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !swrst_o);

   if (!ACK_REG) begin : g_comb_ack
      // R2 / R4: only the address or command value is ever acknowledged
      p_ack_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ack_o |-> (byte_vld_i && (byte_i == GC_ADDR || byte_i == CMD_VAL)));

      // R11: a byte sharing its cycle with START or STOP is not acknowledged
      p_event_noack_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (start_i || stop_i) |-> !ack_o);
   end
endmodule

bind swrst_gc_detect swrst_gc_checker #(
   .BYTE_W (BYTE_W),
   .GC_ADDR(GC_ADDR),
   .CMD_VAL(CMD_VAL),
   .ACK_REG(ACK_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .stop_i    (stop_i),
   .byte_vld_i(byte_vld_i),
   .byte_i    (byte_i),
   .ack_o     (ack_o),
   .swrst_o   (swrst_o)
);

// File: tb/swrst_gc_detect_tb_top.sv
`timescale 1ns/1ps
module swrst_gc_detect_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic       ack_o, swrst_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   swrst_gc_detect dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .ack_o(ack_o), .swrst_o(swrst_o)
   );

   localparam logic [1:0] EV_BYTE = 2'd0, EV_START = 2'd1, EV_STOP = 2'd2, EV_NONE = 2'd3;
   localparam int NV = 35;
   // {req, event, byte, expected ack, expected swrst}
   localparam logic [15:0] VEC [NV] = '{
      {4'd2,  EV_START, 8'h00, 1'b0, 1'b0},
      {4'd2,  EV_BYTE,  8'h00, 1'b1, 1'b0},  // R2 address 00h acked
      {4'd4,  EV_BYTE,  8'h06, 1'b1, 1'b0},  // R4 command acked
      {4'd7,  EV_STOP,  8'h00, 1'b0, 1'b0},
      {4'd7,  EV_NONE,  8'h00, 1'b0, 1'b1},  // R7 pulse after STOP
      {4'd7,  EV_NONE,  8'h00, 1'b0, 1'b0},  // R7 single cycle
      {4'd3,  EV_START, 8'h00, 1'b0, 1'b0},
      {4'd3,  EV_BYTE,  8'h01, 1'b0, 1'b0},  // R3 read address not acked
      {4'd3,  EV_BYTE,  8'h06, 1'b0, 1'b0},  // R3 later byte not acked
      {4'd3,  EV_STOP,  8'h00, 1'b0, 1'b0},
      {4'd3,  EV_NONE,  8'h00, 1'b0, 1'b0},
      {4'd5,  EV_START, 8'h00, 1'b0, 1'b0},
      {4'd5,  EV_BYTE,  8'h00, 1'b1, 1'b0},
      {4'd5,  EV_BYTE,  8'h07, 1'b0, 1'b0},  // R5 wrong command
      {4'd5,  EV_STOP,  8'h00, 1'b0, 1'b0},
      {4'd5,  EV_NONE,  8'h00, 1'b0, 1'b0},  // R5 no pulse
      {4'd6,  EV_START, 8'h00, 1'b0, 1'b0},
      {4'd6,  EV_BYTE,  8'h00, 1'b1, 1'b0},
      {4'd6,  EV_BYTE,  8'h06, 1'b1, 1'b0},
      {4'd6,  EV_BYTE,  8'h06, 1'b0, 1'b0},  // R6 extra byte not acked
      {4'd6,  EV_STOP,  8'h00, 1'b0, 1'b0},
      {4'd6,  EV_NONE,  8'h00, 1'b0, 1'b0},  // R6 reset cancelled
      {4'd8,  EV_START, 8'h00, 1'b0, 1'b0},
      {4'd8,  EV_BYTE,  8'h00, 1'b1, 1'b0},
      {4'd8,  EV_BYTE,  8'h06, 1'b1, 1'b0},
      {4'd8,  EV_START, 8'h00, 1'b0, 1'b0},  // R8 repeated START
      {4'd9,  EV_BYTE,  8'h00, 1'b1, 1'b0},  // R8 no pulse, R9 fresh address acked
      {4'd9,  EV_BYTE,  8'h06, 1'b1, 1'b0},
      {4'd7,  EV_STOP,  8'h00, 1'b0, 1'b0},
      {4'd7,  EV_NONE,  8'h00, 1'b0, 1'b1},
      {4'd10, EV_BYTE,  8'h00, 1'b0, 1'b0},  // R10 no START, no ack
      {4'd10, EV_BYTE,  8'h06, 1'b0, 1'b0},
      {4'd3,  EV_START, 8'h00, 1'b0, 1'b0},
      {4'd3,  EV_BYTE,  8'h02, 1'b0, 1'b0},  // R3 other address
      {4'd3,  EV_NONE,  8'h00, 1'b0, 1'b0}
   };

   task automatic drive(input logic st, input logic sp, input logic bv, input logic [7:0] b);
      @(negedge clk);
      start_i = st; stop_i = sp; byte_vld_i = bv; byte_i = b;
      #1;
   endtask

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "ack after reset", ack_o, 1'b0);
      check("R1", "swrst after reset", swrst_o, 1'b0);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 1'b1, 8'h00);
      check("R1", "byte before any START", ack_o, 1'b0);

      for (int i = 0; i < NV; i++) begin
         logic [15:0] v;
         string rq;
         v = VEC[i];
         drive(v[11:10] == EV_START, v[11:10] == EV_STOP, v[11:10] == EV_BYTE, v[9:2]);
         rq = $sformatf("R%0d", v[15:12]);
         check(rq, $sformatf("ack vec %0d", i), ack_o, v[1]);
         check(rq, $sformatf("swrst vec %0d", i), swrst_o, v[0]);
      end

      // R9: START in the middle of the command phase
      drive(1'b1, 1'b0, 1'b0, 8'h00);
      drive(1'b0, 1'b0, 1'b1, 8'h00);
      check("R9", "address acked", ack_o, 1'b1);
      drive(1'b1, 1'b0, 1'b0, 8'h00);
      drive(1'b0, 1'b0, 1'b1, 8'h06);
      check("R9", "06h taken as address", ack_o, 1'b0);

      // R11: START with byte in the same cycle
      drive(1'b1, 1'b0, 1'b1, 8'h00);
      check("R11", "byte with START", ack_o, 1'b0);
      drive(1'b0, 1'b0, 1'b1, 8'h00);
      check("R11", "address after START", ack_o, 1'b1);
      drive(1'b0, 1'b0, 1'b1, 8'h06);
      check("R11", "command", ack_o, 1'b1);
      // R11: START and STOP together while armed
      drive(1'b1, 1'b1, 1'b0, 8'h00);
      drive(1'b0, 1'b0, 1'b0, 8'h00);
      check("R11", "no pulse on START+STOP", swrst_o, 1'b0);

      // R1: reset while armed clears the pending reset
      drive(1'b0, 1'b0, 1'b1, 8'h00);
      drive(1'b0, 1'b0, 1'b1, 8'h06);
      check("R1", "armed command", ack_o, 1'b1);
      drive(1'b0, 1'b0, 1'b0, 8'h00);
      rst_n = 1'b0;
      #1 rst_n = 1'b1;
      drive(1'b0, 1'b1, 1'b0, 8'h00);
      drive(1'b0, 1'b0, 1'b0, 8'h00);
      check("R1", "no pulse after reset", swrst_o, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule